// File: doc/BRIEF.md
# Low-Transition Intermediate Pattern Sequencer

This block drives test patterns into a circuit under test while keeping the number of bits that toggle between consecutive patterns low. At its heart is a 12-bit generalized shift register built from four 3-bit symbols over GF(8). The register never advances all at once. Each full generator step is split into two half-updates. The first half-update refreshes the two low bits of every symbol, and the second refreshes the top bit of every symbol. Two phases in which nothing advances are placed between them. In those phases part of the output is replaced by fill bits from a separate small LFSR. Each phase also exchanges some output positions between symbol 0 and symbol 1. As a result, four patterns are presented for every generator state.

A four-phase sequencer steps once per cycle in which `run_i` is high, and a 2-bit tag on `phase_o` names the pattern on `pattern_o`. A seed load rearms the sequencer so that the next run cycle begins a new generator step from the loaded seed. Two holding flip-flops keep the last symbol's low bits from before the first half-update. The second half-update therefore sees the same feedback symbol, and each pair of half-updates lands exactly on one full generator step.

Top module: `lt_pattern_seq`

## Requirements
- R1: During and after the synchronous active-low reset, `phase_o` is 3, the register holds 12'hFFF, the fill source holds 12'hACE, and `pattern_o` follows R6 for that content.
- R2: Each cycle with `run_i` high and `load_i` low moves `phase_o` through 0, 1, 2, 3 and back to 0. A cycle with both low leaves `phase_o` and `pattern_o` unchanged.
- R3: On entering tag 0, the low two bits of every symbol (positions 0,1,3,4,6,7,9,10) take their next-state value and the top bits (2,5,8,11) hold. The output is the register with bits 2:0 and 5:3 exchanged.
- R4: In tag 1 the register holds. Positions 2,5,8,11 show the fill bits of the same index, and the output bits 1:0 and 4:3 are exchanged.
- R5: On entering tag 2, the top bits advance and the low bits hold. The register then equals one full generator step of the state held before tag 0, and the output is that state with bits 2:0 and 5:3 exchanged.
- R6: In tag 3 the register holds. Positions 0,1,3,4,6,7,9,10 show fill bits of the same index, and output bits 2 and 5 are exchanged.
- R7: A full generator step uses symbol k = bits [3k+2:3k] and feedback f = symbol 3. The new symbol 0 is c0·f, and the new symbol k is symbol k-1 XOR ck·f. Products are in GF(8) modulo x^3+x+1, with c0=3'b011, c1=3'b110, c2=3'b101 and c3=3'b010. An all-zero state stays zero.
- R8: The fill source shifts left once per advancing cycle, with new bit 0 = b11^b10^b9^b3. It does not move during load cycles or cycles without run.
- R9: `load_i` high captures `seed_i`, sets `phase_o` to 3 and overrides `run_i`. The next run cycle enters tag 0 from the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Load `seed_i` and rearm the sequencer |
| seed_i | input | 12 | Seed for the generator register |
| run_i | input | 1 | Advance one phase this cycle |
| pattern_o | output | 12 | Presented test pattern |
| phase_o | output | 2 | Tag of the presented pattern (0..3) |

## Verification
The assertions check every cycle that the tag moves in order, that a stall freezes both outputs, and that a load rearms to tag 3. At each phase change they also check that the positions showing the half of the register not being updated keep their values. Only the bench scenarios can show that those kept values are right: that the two half-updates together equal the reference GF(8) step, and that fill bits appear at the correct positions in the correct order. They also show the corner cases: an all-zero seed, a stall inside a fill phase, a load coinciding with run, and a reset in mid-sequence.

// File: rtl/ltpg_pkg.sv
`timescale 1ns/1ps
// Shared phase encoding and per-phase control code for the sequencer.
// Assumes exactly four phases and a two-bit tag.
package ltpg_pkg;

    typedef enum logic [1:0] {
        PH_STEP_LO = 2'd0,
        PH_FILL_HI = 2'd1,
        PH_STEP_HI = 2'd2,
        PH_FILL_LO = 2'd3
    } phase_e;

    // step_lo/step_hi: which half advances; show_lo/show_hi: which half is seen
    typedef struct packed {
        logic step_lo;
        logic step_hi;
        logic show_lo;
        logic show_hi;
    } ctrl_s;

    // Control code for a phase
    function automatic ctrl_s ctrl_of(input phase_e ph);
        ctrl_s c;
        case (ph)
            PH_STEP_LO: c = '{step_lo: 1'b1, step_hi: 1'b0, show_lo: 1'b1, show_hi: 1'b1};
            PH_FILL_HI: c = '{step_lo: 1'b0, step_hi: 1'b0, show_lo: 1'b1, show_hi: 1'b0};
            PH_STEP_HI: c = '{step_lo: 1'b0, step_hi: 1'b1, show_lo: 1'b1, show_hi: 1'b1};
            default:    c = '{step_lo: 1'b0, step_hi: 1'b0, show_lo: 1'b0, show_hi: 1'b1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ltpg_phase_ctrl.sv
`timescale 1ns/1ps
// Four-phase sequencer. Moves one phase per run cycle. A load parks it in
// the last phase, so the next run cycle enters the low-half step.
// The half-update strobes belong to the phase being entered at this edge.
// Assumes load_i has priority over run_i.
module ltpg_phase_ctrl
    import ltpg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load_i,
    input  logic   run_i,
    output phase_e phase_q,
    output ctrl_s  cur_ctrl,
    output logic   step_lo,
    output logic   step_hi,
    output logic   advance
);
    phase_e phase_n;
    ctrl_s  nxt_ctrl;

    // Next phase in the ring and the codes of current and next phase
    assign phase_n  = phase_e'(phase_q + 2'd1);
    assign nxt_ctrl = ctrl_of(phase_n);
    assign cur_ctrl = ctrl_of(phase_q);

    // Strobes for this edge: only when running and not loading
    assign advance = run_i & ~load_i;
    assign step_lo = advance & nxt_ctrl.step_lo;
    assign step_hi = advance & nxt_ctrl.step_hi;

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_FILL_LO;
        end else if (load_i) begin
            phase_q <= PH_FILL_LO;
        end else if (run_i) begin
            phase_q <= phase_n;
        end
    end
endmodule

// File: rtl/ltpg_split_core.sv
`timescale 1ns/1ps
// Generalized shift register over GF(2^SYM_W) with STAGES symbols. It is
// updated in two halves. step_lo refreshes the low SYM_W-1 bits of every
// symbol and stores the old low bits of the feedback symbol. step_hi then
// refreshes the top bit of every symbol, using the stored bits together
// with the unchanged top bit, so the two halves equal one full step.
// Assumes step_lo and step_hi are never high together, and step_lo precedes step_hi.
module ltpg_split_core #(
    parameter int                          SYM_W      = 3,
    parameter int                          STAGES     = 4,
    parameter logic [SYM_W*STAGES-1:0]     COEFS      = 12'h573,
    parameter logic [SYM_W-1:0]            FIELD_POLY = 3'b011,
    parameter logic [SYM_W*STAGES-1:0]     RESET_SEED = 12'hFFF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [SYM_W*STAGES-1:0] seed_i,
    input  logic                    step_lo,
    input  logic                    step_hi,
    output logic [SYM_W*STAGES-1:0] state_q
);
    localparam int N      = SYM_W * STAGES;
    localparam int HOLD_W = SYM_W - 1;

    logic [HOLD_W-1:0] hold_q;
    logic [SYM_W-1:0]  fb_now;
    logic [SYM_W-1:0]  fb_old;
    logic [N-1:0]      state_n;

    // Constant multiply in the symbol field
    function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a_in,
                                                input logic [SYM_W-1:0] b_in);
        logic [SYM_W-1:0] a;
        logic [SYM_W-1:0] acc;
        a   = a_in;
        acc = '0;
        for (int k = 0; k < SYM_W; k++) begin
            if (b_in[k]) acc = acc ^ a;
            a = {a[SYM_W-2:0], 1'b0} ^ (a[SYM_W-1] ? FIELD_POLY : '0);
        end
        return acc;
    endfunction

    // Feedback symbol now, and as it was before the low-half update
    assign fb_now = state_q[N-1 -: SYM_W];
    assign fb_old = {state_q[N-1], hold_q};

    // Per-symbol next values for each half
    for (genvar i = 0; i < STAGES; i++) begin : g_sym
        logic [SYM_W-1:0] up;
        logic [SYM_W-1:0] full_now;
        logic [SYM_W-1:0] prod_old;
        if (i == 0) begin : g_first
            assign up = '0;
        end else begin : g_rest
            assign up = state_q[(i-1)*SYM_W +: SYM_W];
        end
        assign full_now = up ^ gf_mul(COEFS[i*SYM_W +: SYM_W], fb_now);
        assign prod_old = gf_mul(COEFS[i*SYM_W +: SYM_W], fb_old);
        assign state_n[i*SYM_W +: HOLD_W] = step_lo ? full_now[HOLD_W-1:0]
                                                    : state_q[i*SYM_W +: HOLD_W];
        assign state_n[i*SYM_W + SYM_W - 1] = step_hi
            ? (up[SYM_W-1] ^ prod_old[SYM_W-1])
            : state_q[i*SYM_W + SYM_W - 1];
    end

    // Register and holding flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESET_SEED;
            hold_q  <= '0;
        end else if (load_i) begin
            state_q <= seed_i;
            hold_q  <= seed_i[N-SYM_W +: HOLD_W];
        end else begin
            state_q <= state_n;
            if (step_lo) hold_q <= fb_now[HOLD_W-1:0];
        end
    end
endmodule

// File: rtl/ltpg_fill_src.sv
`timescale 1ns/1ps
// Fibonacci LFSR that supplies fill bits. It shifts left once per advancing
// cycle and feeds the XOR of the tapped bits into bit 0.
// Assumes SEED is nonzero.
module ltpg_fill_src #(
    parameter int               WIDTH = 12,
    parameter logic [WIDTH-1:0] TAPS  = 12'hE08,
    parameter logic [WIDTH-1:0] SEED  = 12'hACE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [WIDTH-1:0] fill_q
);
    // Shift register with tapped feedback
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= SEED;
        end else if (advance) begin
            fill_q <= {fill_q[WIDTH-2:0], ^(fill_q & TAPS)};
        end
    end
endmodule

// File: rtl/ltpg_out_mux.sv
`timescale 1ns/1ps
// Builds the presented pattern. Positions of a half that is not shown take
// fill bits of the same index. Then, wherever symbol 0 shows register bits,
// those positions are exchanged with the same positions of symbol 1.
// Assumes STAGES >= 2. Purely combinational.
module ltpg_out_mux #(
    parameter int SYM_W  = 3,
    parameter int STAGES = 4
) (
    input  logic [SYM_W*STAGES-1:0] state_i,
    input  logic [SYM_W*STAGES-1:0] fill_i,
    input  logic                    show_lo,
    input  logic                    show_hi,
    output logic [SYM_W*STAGES-1:0] pattern_o
);
    localparam int N = SYM_W * STAGES;

    logic [N-1:0] show;
    logic [N-1:0] mixed;

    // Per-bit choice between register and fill
    always_comb begin
        for (int i = 0; i < STAGES; i++) begin
            for (int b = 0; b < SYM_W; b++) begin
                show[i*SYM_W + b] = (b == SYM_W - 1) ? show_hi : show_lo;
            end
        end
        mixed = (state_i & show) | (fill_i & ~show);
    end

    // Exchange the shown positions of symbols 0 and 1
    always_comb begin
        pattern_o = mixed;
        for (int b = 0; b < SYM_W; b++) begin
            if (show[b]) begin
                pattern_o[b]         = mixed[SYM_W + b];
                pattern_o[SYM_W + b] = mixed[b];
            end
        end
    end
endmodule

// File: rtl/lt_pattern_seq.sv
`timescale 1ns/1ps
// Low-transition pattern sequencer top. Presents four patterns per
// generator state: low-half step, top-bit fill, top-bit step, low-bit fill.
// Assumes the default geometry gives a 12-bit pattern; the ports follow N.
module lt_pattern_seq
    import ltpg_pkg::*;
#(
    parameter int                      SYM_W      = 3,
    parameter int                      STAGES     = 4,
    parameter logic [SYM_W*STAGES-1:0] COEFS      = 12'h573,
    parameter logic [SYM_W-1:0]        FIELD_POLY = 3'b011,
    parameter logic [SYM_W*STAGES-1:0] RESET_SEED = 12'hFFF,
    parameter logic [SYM_W*STAGES-1:0] FILL_TAPS  = 12'hE08,
    parameter logic [SYM_W*STAGES-1:0] FILL_SEED  = 12'hACE
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [SYM_W*STAGES-1:0] seed_i,
    input  logic                    run_i,
    output logic [SYM_W*STAGES-1:0] pattern_o,
    output logic [1:0]              phase_o
);
    localparam int N = SYM_W * STAGES;

    phase_e       phase_q;
    ctrl_s        cur_ctrl;
    logic         step_lo;
    logic         step_hi;
    logic         advance;
    logic [N-1:0] state_q;
    logic [N-1:0] fill_q;

    ltpg_phase_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .run_i    (run_i),
        .phase_q  (phase_q),
        .cur_ctrl (cur_ctrl),
        .step_lo  (step_lo),
        .step_hi  (step_hi),
        .advance  (advance)
    );

    ltpg_split_core #(
        .SYM_W      (SYM_W),
        .STAGES     (STAGES),
        .COEFS      (COEFS),
        .FIELD_POLY (FIELD_POLY),
        .RESET_SEED (RESET_SEED)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .seed_i  (seed_i),
        .step_lo (step_lo),
        .step_hi (step_hi),
        .state_q (state_q)
    );

    ltpg_fill_src #(
        .WIDTH (N),
        .TAPS  (FILL_TAPS),
        .SEED  (FILL_SEED)
    ) u_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .fill_q  (fill_q)
    );

    ltpg_out_mux #(
        .SYM_W  (SYM_W),
        .STAGES (STAGES)
    ) u_mux (
        .state_i   (state_q),
        .fill_i    (fill_q),
        .show_lo   (cur_ctrl.show_lo),
        .show_hi   (cur_ctrl.show_hi),
        .pattern_o (pattern_o)
    );

    // Tag of the presented pattern
    assign phase_o = phase_q;
endmodule

// File: rtl/lt_pattern_seq_chk.sv
`timescale 1ns/1ps
// Checker bound to the sequencer top. It watches only the ports: tag order,
// stall behaviour, load rearm, and the output positions that must keep their
// value when the phase changes.
module lt_pattern_seq_chk #(
    parameter int SYM_W  = 3,
    parameter int STAGES = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    load_i,
    input logic                    run_i,
    input logic [1:0]              phase_o,
    input logic [SYM_W*STAGES-1:0] pattern_o
);
    localparam int N = SYM_W * STAGES;

    function automatic logic [N-1:0] top_mask();
        logic [N-1:0] m;
        m = '0;
        for (int i = 0; i < STAGES; i++) m[i*SYM_W + SYM_W - 1] = 1'b1;
        return m;
    endfunction

    localparam logic [N-1:0] HI = top_mask();
    localparam logic [N-1:0] LO = ~HI;

    logic adv;
    assign adv = run_i & ~load_i;

    // R2: tag advances by one per run cycle
    a_r2_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> phase_o == $past(phase_o) + 2'd1);

    // R2: stall freezes tag and pattern
    a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> ($stable(phase_o) && $stable(pattern_o)));

    // R9: load rearms to tag 3
    a_r9_load_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> phase_o == 2'd3);

    // R3: entering tag 0 keeps the top-bit positions
    a_r3_hi_held: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && phase_o == 2'd3) |=> (pattern_o & HI) == ($past(pattern_o) & HI));

    // R4: entering tag 1 keeps the low-bit positions
    a_r4_lo_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && phase_o == 2'd0) |=> (pattern_o & LO) == ($past(pattern_o) & LO));

    // R5: entering tag 2 keeps the low-bit positions
    a_r5_lo_held: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && phase_o == 2'd1) |=> (pattern_o & LO) == ($past(pattern_o) & LO));

    // R6: entering tag 3 keeps the top-bit positions
    a_r6_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && phase_o == 2'd2) |=> (pattern_o & HI) == ($past(pattern_o) & HI));
endmodule

bind lt_pattern_seq lt_pattern_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .run_i     (run_i),
    .phase_o   (phase_o),
    .pattern_o (pattern_o)
);

// File: tb/lt_pattern_seq_tb_top.sv
`timescale 1ns/1ps
module lt_pattern_seq_tb_top;
    localparam logic [11:0] LO_POS     = 12'h6DB;
    localparam logic [11:0] RESET_SEED = 12'hFFF;
    localparam logic [11:0] FILL_SEED  = 12'hACE;
    localparam logic [2:0]  C0 = 3'b011, C1 = 3'b110, C2 = 3'b101, C3 = 3'b010;
    // {seed, generator steps}
    localparam logic [19:0] VECS [6] = '{
        {12'hFFF, 8'd6}, {12'h001, 8'd5}, {12'h800, 8'd5},
        {12'hA5C, 8'd8}, {12'h3C3, 8'd4}, {12'h000, 8'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [11:0] seed_i = '0;
    logic        run_i = 1'b0;
    logic [11:0] pattern_o;
    logic [1:0]  phase_o;

    int checks = 0;
    int fails  = 0;
    logic [11:0] m_prev, m_next, m_fill;

    always #10 clk = ~clk;

    lt_pattern_seq dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .seed_i(seed_i),
        .run_i(run_i), .pattern_o(pattern_o), .phase_o(phase_o)
    );

    function automatic logic [2:0] gmul(input logic [2:0] a_in, input logic [2:0] b);
        logic [2:0] a;
        logic [2:0] acc;
        a = a_in;
        acc = '0;
        for (int k = 0; k < 3; k++) begin
            if (b[k]) acc = acc ^ a;
            a = {a[1:0], 1'b0} ^ (a[2] ? 3'b011 : 3'b000);
        end
        return acc;
    endfunction

    // R7 reference step
    function automatic logic [11:0] gstep(input logic [11:0] s);
        logic [2:0] f;
        f = s[11:9];
        return {s[8:6] ^ gmul(C3, f), s[5:3] ^ gmul(C2, f),
                s[2:0] ^ gmul(C1, f), gmul(C0, f)};
    endfunction

    // R8 reference fill step
    function automatic logic [11:0] fstep(input logic [11:0] v);
        return {v[10:0], v[11] ^ v[10] ^ v[9] ^ v[3]};
    endfunction

    function automatic logic [11:0] xchg(input logic [11:0] v, input logic [2:0] m);
        logic [11:0] r;
        r = v;
        for (int b = 0; b < 3; b++) if (m[b]) begin r[b] = v[b+3]; r[b+3] = v[b]; end
        return r;
    endfunction

    // Expected pattern for a tag, from R3..R6
    function automatic logic [11:0] exp_pat(input int ph, input logic [11:0] prv,
                                            input logic [11:0] nxt, input logic [11:0] fil);
        logic [11:0] half;
        half = (nxt & LO_POS) | (prv & ~LO_POS);
        case (ph)
            0:       return xchg(half, 3'b111);
            1:       return xchg((half & LO_POS) | (fil & ~LO_POS), 3'b011);
            2:       return xchg(nxt, 3'b111);
            default: return xchg((nxt & ~LO_POS) | (fil & LO_POS), 3'b100);
        endcase
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One run cycle for tag ph, then compare at the falling edge
    task automatic step_phase(input int ph, input string req);
        run_i = 1'b1;
        @(posedge clk);
        m_fill = fstep(m_fill);
        if (ph == 0) begin m_prev = m_next; m_next = gstep(m_prev); end
        @(negedge clk);
        check({req, " tag"}, {10'd0, phase_o}, 12'(ph));
        check(req, pattern_o, exp_pat(ph, m_prev, m_next, m_fill));
    endtask

    task automatic load_seed(input logic [11:0] s, input logic with_run);
        load_i = 1'b1; seed_i = s; run_i = with_run;
        @(posedge clk);
        @(negedge clk);
        load_i = 1'b0; run_i = 1'b0;
        m_prev = s; m_next = s;
        check("R9 tag after load", {10'd0, phase_o}, 12'd3);
        check("R9 pattern after load", pattern_o, exp_pat(3, s, s, m_fill));
    endtask

    initial begin
        // Watchdog
        #4000000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        m_fill = FILL_SEED; m_next = RESET_SEED; m_prev = RESET_SEED;
        repeat (3) @(negedge clk);
        check("R1 tag in reset", {10'd0, phase_o}, 12'd3);
        rst_n = 1'b1;
        check("R1 reset pattern", pattern_o, exp_pat(3, RESET_SEED, RESET_SEED, FILL_SEED));

        // R3 R4 R5 R6: run straight from reset
        for (int p = 0; p < 8; p++) step_phase(p % 4, "R5 from reset");

        // Table walk: R3 R4 R5 R6 R7 R8 R9
        foreach (VECS[v]) begin
            load_seed(VECS[v][19:8], 1'b0);
            for (int s = 0; s < int'(VECS[v][7:0]); s++) begin
                step_phase(0, "R3 low step");
                step_phase(1, "R4 top fill");
                step_phase(2, "R5 top step");
                step_phase(3, "R6 low fill");
            end
            run_i = 1'b0;
        end

        // R7: zero seed stays zero after a full step
        load_seed(12'h000, 1'b0);
        step_phase(0, "R7 zero");
        step_phase(1, "R7 zero");
        step_phase(2, "R7 zero");
        check("R7 zero state", xchg(pattern_o, 3'b111), 12'h000);

        // R2 R8: stall inside a fill phase
        load_seed(12'h5A3, 1'b0);
        step_phase(0, "R2 pre-stall");
        step_phase(1, "R2 pre-stall");
        run_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 stall tag", {10'd0, phase_o}, 12'd1);
        check("R8 stall fill frozen", pattern_o, exp_pat(1, m_prev, m_next, m_fill));
        step_phase(2, "R2 resume");
        step_phase(3, "R2 resume");
        step_phase(0, "R2 resume");

        // R9: load together with run overrides run
        load_seed(12'h1E7, 1'b1);
        for (int p = 0; p < 8; p++) step_phase(p % 4, "R9 after load+run");

        // R1: reset in mid-sequence
        step_phase(0, "R1 pre-reset");
        run_i = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_fill = FILL_SEED; m_next = RESET_SEED; m_prev = RESET_SEED;
        check("R1 tag after mid reset", {10'd0, phase_o}, 12'd3);
        check("R1 pattern after mid reset", pattern_o,
              exp_pat(3, RESET_SEED, RESET_SEED, FILL_SEED));
        for (int p = 0; p < 4; p++) step_phase(p % 4, "R1 restart");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule